// File: doc/BRIEF.md
# DDR Read-Capture Delay Tap Calibration Sweeper

This block searches for a usable read-capture delay setting on a DDR interface without software involvement. After a one-cycle start pulse it walks a delay tap upward from zero through its whole range. It drives the current tap identically onto the delay inputs of every byte lane. For each tap it launches an external memory self-test engine and waits for completion. From the reported fail and pass counts it decides whether the tap is good.

While sweeping, the block keeps a count of good taps and records the lowest and highest good tap. The lowest-tap register begins each sweep holding the marker word 0xAA55AA55, and that marker is how the block recognises its first good tap. Once the top tap has been tested, the block programs the midpoint of the good window onto all lanes. If no tap was good, it programs a fixed default instead. A done flag then stays high until the next start. The good-tap count and both window edges are visible as outputs.

Top module: `ddr_tap_sweeper`

## Requirements
- R1: A sweep tests the taps 0, 1, 2, … 63 in ascending order, exactly once each, and stops after tap 63 has been judged.
- R2: All four lane delay outputs carry the same tap at all times: the tap under test during a sweep, and the chosen tap afterwards.
- R3: For each tap `bistStart` rises and stays high until bit 0 of `bistStatus` (done) reads 1. It is low from the next cycle. The following tap is not launched until done has returned to 0.
- R4: In `bistStatus`, bits 8:1 are the count of passing runs and bits 16:9 are the count of failing runs.
- R5: The expected run count is `runCfg[8:1]` (8 runs is written as `runCfg[8:1]` = 8). A tap is good only when the fail count is zero and the pass count equals the expected run count.
- R6: Each good tap increments `passCount`. The first good tap of a sweep loads both `firstPass` and `lastPass`, and each later good tap loads only `lastPass`.
- R7: From a start until the first good tap, `firstPass` holds 32'hAA55AA55.
- R8: If `passCount` is zero after tap 63, the chosen tap is 8.
- R9: Otherwise the chosen tap is (first + last) >> 1, kept to 6 bits.
- R10: A one-cycle `start` in idle or done clears the results and begins a sweep. `start` during a sweep has no effect. `done` rises with the chosen tap applied and holds until the next start.
- R11: After reset, `bistStart`, `busy` and `done` are 0, the lanes carry tap 0, `passCount` and `lastPass` are 0, and `firstPass` is 32'hAA55AA55.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a sweep |
| runCfg | input | 8 (bits 8:1) | Expected number of self-test runs per tap |
| bistStatus | input | 17 | Self-test status: bit 0 done, 8:1 passes, 16:9 fails |
| bistStart | output | 1 | Launch and hold request to the self-test engine |
| laneTap | output | 24 | Four 6-bit lane delay settings, lane 0 in bits 5:0 |
| finalTap | output | 6 | Tap currently applied to the lanes |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Sweep finished and chosen tap applied |
| passCount | output | 7 | Number of good taps in this sweep |
| firstPass | output | 32 | Lowest good tap, or the marker word before any |
| lastPass | output | 6 | Highest good tap so far |

## Verification
A start sampled at one clock edge makes `bistStart` high directly after that edge. A done level seen at an edge drops `bistStart` and updates `passCount`, `firstPass` and `lastPass` after that same edge. Done seen low at a later edge moves the lanes to the next tap and relaunches, or, after tap 63, applies the chosen tap and raises `done` at that edge. The bench has a behavioural model that advances on each rising edge from the same sampled inputs. It compares every output at the following falling edge, so each result is checked in the exact cycle it is due. Per-sweep checks of the tested tap sequence, the window and the chosen tap are added on top.

// File: rtl/tap_sweep_pkg.sv
package tap_sweep_pkg;

  // Strobes issued by the sequencer to the datapath, at most one per cycle.
  typedef struct packed {
    logic clearAll;    // restart: tap to 0, results cleared
    logic judge;       // self-test done: grade current tap
    logic stepTap;     // advance to the next tap
    logic applyFinal;  // load the chosen tap
  } sweepStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_TEST    = 2'd1,
    ST_RELEASE = 2'd2,
    ST_DONE    = 2'd3
  } sweepState_t;

endpackage

// File: rtl/tap_sweep_ctrl.sv
module tap_sweep_ctrl
  import tap_sweep_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          bistDone,
  input  logic          tapAtEnd,
  output sweepStrobes_t strb,
  output logic          bistStart,
  output logic          busy,
  output logic          done
);

  sweepState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          strb.clearAll = 1'b1;
          stateNext     = ST_TEST;
        end
      end
      ST_TEST: begin
        if (bistDone) begin
          strb.judge = 1'b1;
          stateNext  = ST_RELEASE;
        end
      end
      ST_RELEASE: begin
        if (!bistDone) begin
          if (tapAtEnd) begin
            strb.applyFinal = 1'b1;
            stateNext       = ST_DONE;
          end else begin
            strb.stepTap = 1'b1;
            stateNext    = ST_TEST;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign bistStart = (state == ST_TEST);
  assign busy      = (state == ST_TEST) || (state == ST_RELEASE);
  assign done      = (state == ST_DONE);

  // R3: request held until the engine reports done
  assert_hold_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    (bistStart && !bistDone) |=> bistStart);

  // R3: request withdrawn the cycle after done is seen
  assert_drop_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    (bistStart && bistDone) |=> !bistStart);

  // R3: no relaunch while done is still high
  assert_wait_release_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !bistStart && bistDone) |=> !bistStart);

  // R10: done persists until a new start
  assert_done_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  // R10: a start during a sweep does not restart it
  assert_busy_ignores_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !bistStart && bistDone) |=> (busy && !bistStart));

endmodule

// File: rtl/tap_sweep_datapath.sv
module tap_sweep_datapath
  import tap_sweep_pkg::*;
#(
  parameter int TAP_W       = 6,
  parameter int CNT_W       = 8,
  parameter int MARK_W      = 32,
  parameter int DEFAULT_TAP = 8,
  parameter logic [MARK_W-1:0] MARKER = 32'hAA55AA55
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  sweepStrobes_t        strb,
  input  logic [2*CNT_W:0]     bistStatus,
  input  logic [CNT_W:1]       runCfg,
  output logic [TAP_W-1:0]     appliedTap,
  output logic                 tapAtEnd,
  output logic [TAP_W:0]       passCount,
  output logic [MARK_W-1:0]    firstPass,
  output logic [TAP_W-1:0]     lastPass
);

  localparam int PASS_LSB = 1;
  localparam int FAIL_LSB = PASS_LSB + CNT_W;
  localparam int PCNT_W   = TAP_W + 1;
  localparam logic [TAP_W-1:0] TAP_MAX = {TAP_W{1'b1}};
  localparam logic [TAP_W-1:0] DEF_TAP = TAP_W'(DEFAULT_TAP);

  logic [CNT_W-1:0] passRuns, failRuns, cfgRuns;
  logic             tapGood, noPassYet;
  logic [TAP_W:0]   windowSum;
  logic [TAP_W-1:0] centreTap, chosenTap;

  assign passRuns  = bistStatus[PASS_LSB +: CNT_W];
  assign failRuns  = bistStatus[FAIL_LSB +: CNT_W];
  assign cfgRuns   = runCfg;
  assign tapGood   = (failRuns == '0) && (passRuns == cfgRuns);
  assign noPassYet = (firstPass == MARKER);
  assign tapAtEnd  = (appliedTap == TAP_MAX);

  assign windowSum = {1'b0, firstPass[TAP_W-1:0]} + {1'b0, lastPass};
  assign centreTap = windowSum[TAP_W:1];
  assign chosenTap = (passCount == '0) ? DEF_TAP : centreTap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      appliedTap <= '0;
      passCount  <= '0;
      firstPass  <= MARKER;
      lastPass   <= '0;
    end else begin
      if (strb.clearAll) begin
        appliedTap <= '0;
        passCount  <= '0;
        firstPass  <= MARKER;
        lastPass   <= '0;
      end
      if (strb.judge && tapGood) begin
        passCount <= passCount + PCNT_W'(1);
        lastPass  <= appliedTap;
        if (noPassYet) firstPass <= {{(MARK_W-TAP_W){1'b0}}, appliedTap};
      end
      if (strb.stepTap)    appliedTap <= appliedTap + TAP_W'(1);
      if (strb.applyFinal) appliedTap <= chosenTap;
    end
  end

  // R7: marker stays in place until a good tap is seen
  assert_marker_R7: assert property (@(posedge clk) disable iff (!rstN)
    (passCount == '0) |-> (firstPass == MARKER));

  // R6: window edges ordered once a good tap exists
  assert_window_order_R6: assert property (@(posedge clk) disable iff (!rstN)
    (passCount != '0) |-> (lastPass >= firstPass[TAP_W-1:0]));

  // R6: good-tap count only holds or steps by one outside a restart
  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clearAll |=> ((passCount == $past(passCount)) ||
                        (passCount == $past(passCount) + PCNT_W'(1))));

  // R8: empty window yields the fallback tap
  assert_fallback_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.applyFinal && passCount == '0) |=> (appliedTap == DEF_TAP));

  // R1: the tap only moves forward by one during a sweep
  assert_tap_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepTap |=> (appliedTap == $past(appliedTap) + TAP_W'(1)));

endmodule

// File: rtl/ddr_tap_sweeper.sv
module ddr_tap_sweeper
  import tap_sweep_pkg::*;
#(
  parameter int TAP_W       = 6,
  parameter int LANES       = 4,
  parameter int CNT_W       = 8,
  parameter int MARK_W      = 32,
  parameter int DEFAULT_TAP = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [CNT_W:1]         runCfg,
  input  logic [2*CNT_W:0]       bistStatus,
  output logic                   bistStart,
  output logic [LANES*TAP_W-1:0] laneTap,
  output logic [TAP_W-1:0]       finalTap,
  output logic                   busy,
  output logic                   done,
  output logic [TAP_W:0]         passCount,
  output logic [MARK_W-1:0]      firstPass,
  output logic [TAP_W-1:0]       lastPass
);

  sweepStrobes_t    strb;
  logic             tapAtEnd;
  logic [TAP_W-1:0] appliedTap;

  tap_sweep_ctrl ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .bistDone  (bistStatus[0]),
    .tapAtEnd  (tapAtEnd),
    .strb      (strb),
    .bistStart (bistStart),
    .busy      (busy),
    .done      (done)
  );

  tap_sweep_datapath #(
    .TAP_W       (TAP_W),
    .CNT_W       (CNT_W),
    .MARK_W      (MARK_W),
    .DEFAULT_TAP (DEFAULT_TAP)
  ) dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .bistStatus (bistStatus),
    .runCfg     (runCfg),
    .appliedTap (appliedTap),
    .tapAtEnd   (tapAtEnd),
    .passCount  (passCount),
    .firstPass  (firstPass),
    .lastPass   (lastPass)
  );

  // R2: one shared tap fanned out to every lane
  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    assign laneTap[ln*TAP_W +: TAP_W] = appliedTap;
  end

  assign finalTap = appliedTap;

endmodule

// File: tb/ddr_tap_sweeper_test.sv
`timescale 1ns/1ps
module ddr_tap_sweeper_test;

  localparam logic [31:0] MARK = 32'hAA55AA55;

  logic        clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [8:1]  runCfg = 8'd8;
  logic [16:0] bistStatus = '0;
  logic        bistStart, busy, done;
  logic [23:0] laneTap;
  logic [5:0]  finalTap, lastPass;
  logic [6:0]  passCount;
  logic [31:0] firstPass;

  ddr_tap_sweeper uut (
    .clk(clk), .rstN(rstN), .start(start), .runCfg(runCfg),
    .bistStatus(bistStatus), .bistStart(bistStart), .laneTap(laneTap),
    .finalTap(finalTap), .busy(busy), .done(done), .passCount(passCount),
    .firstPass(firstPass), .lastPass(lastPass)
  );

  always #2 clk = ~clk;

  int nChecks = 0, nErrors = 0, cyc = 0, sc = 0, respCnt = 0;

  // behavioural reference state
  int          mMode = 0, mTap = 0, mCnt = 0, mLast = 0;
  logic [31:0] mFirst = MARK;
  int          tested[$];

  task automatic chkEq(input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R4/R5 stimulus: status word per scenario and tap
  function automatic logic [16:0] respWord(input int s, input int tap);
    int p, f;
    case (s)
      0: begin p = (tap >= 20 && tap <= 40) ? 8 : 5; f = (tap >= 20 && tap <= 40) ? 0 : 3; end
      1: begin p = 0; f = 8; end
      2: begin
        if (tap == 63)      begin p = 8; f = 0; end
        else if (tap >= 30) begin p = 7; f = 0; end
        else                begin p = 8; f = 1; end
      end
      3: begin p = 8; f = 0; end
      default: begin
        p = ((tap >= 5 && tap <= 10) || (tap >= 50 && tap <= 52)) ? 3 : 8;
        f = 0;
      end
    endcase
    return {f[7:0], p[7:0], 1'b1};
  endfunction

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mTap = 0; mCnt = 0; mFirst = MARK; mLast = 0;
    end else begin
      case (mMode)
        0, 3: if (start) begin
          mMode = 1; mTap = 0; mCnt = 0; mFirst = MARK; mLast = 0;
          tested.delete();
        end
        1: if (bistStatus[0]) begin
          tested.push_back(mTap);
          if (bistStatus[16:9] == 0 && bistStatus[8:1] == runCfg) begin
            mCnt++;
            if (mFirst == MARK) mFirst = 32'(mTap);
            mLast = mTap;
          end
          mMode = 2;
        end
        2: if (!bistStatus[0]) begin
          if (mTap == 63) begin
            mTap  = (mCnt == 0) ? 8 : ((int'(mFirst[5:0]) + mLast) / 2) % 64;
            mMode = 3;
          end else begin
            mTap++;
            mMode = 1;
          end
        end
        default: mMode = 0;
      endcase
    end
  end

  // compare on every falling edge, then update the engine responder
  always @(negedge clk) begin
    cyc++;
    chkEq("R3", "bistStart", bistStart, mMode == 1);
    chkEq("R10", "done", done, mMode == 3);
    chkEq("R10", "busy", busy, mMode == 1 || mMode == 2);
    for (int ln = 0; ln < 4; ln++)
      chkEq("R2", "laneTap", laneTap[ln*6 +: 6], mTap);
    chkEq("R1", "finalTap", finalTap, mTap);
    chkEq("R6", "passCount", passCount, mCnt);
    chkEq("R7", "firstPass", firstPass, mFirst);
    chkEq("R6", "lastPass", lastPass, mLast);
    if (bistStart) begin
      respCnt++;
      if (respCnt >= 1 + (int'(laneTap[5:0]) % 3))
        bistStatus = respWord(sc, int'(laneTap[5:0]));
    end else begin
      respCnt = 0;
      bistStatus = '0;
    end
    if (cyc > 150000) begin
      nErrors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  task automatic runSweep(input int s, input int runs, input bit poke,
                          input int expFinal, input int expCnt,
                          input int expFirst, input int expLast);
    bit ok;
    @(negedge clk);
    sc = s; runCfg = runs[7:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 5000 && !done; i++) begin
      if (poke && i == 40) start = 1'b1;  // R10: ignored mid-sweep
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chkEq("R10", "done after sweep", done, 1);
    ok = (tested.size() == 64);
    foreach (tested[k]) if (tested[k] != k) ok = 1'b0;
    chkEq("R1", "ascending 0..63 once each", ok, 1);
    chkEq(expCnt == 0 ? "R8" : "R9", "chosen tap", finalTap, expFinal);
    chkEq("R6", "good tap count", passCount, expCnt);
    if (expCnt == 0) chkEq("R7", "marker kept", firstPass, MARK);
    else begin
      chkEq("R6", "first good tap", firstPass, expFirst);
      chkEq("R6", "last good tap", lastPass, expLast);
    end
    repeat (4) @(negedge clk);
    chkEq("R10", "done held", done, 1);
    chkEq("R2", "lane 3 holds chosen tap", laneTap[23:18], expFinal);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chkEq("R11", "reset firstPass", firstPass, MARK);
    chkEq("R11", "reset bistStart", bistStart, 0);
    chkEq("R11", "reset lanes", laneTap, 0);
    rstN = 1'b1;
    runSweep(0, 8, 1'b1, 30, 21, 20, 40);   // R5 window with fail counts outside
    runSweep(1, 8, 1'b0, 8, 0, 0, 0);       // R8 nothing passes
    runSweep(2, 8, 1'b0, 63, 1, 63, 63);    // R4/R5 count mismatch, top tap only
    runSweep(3, 8, 1'b0, 31, 64, 0, 63);    // R9 full range
    runSweep(4, 3, 1'b0, 28, 9, 5, 52);     // R5/R9 two islands, odd sum
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule